// File: doc/BRIEF.md
# Paged Store Transfer Controller with Verify

The controller moves blocks of 40-bit words between a large backing store, organised as numbered tracks, and a small working store, organised as pages. One command names a direction, a track, a page, and whether a whole track or half a track moves. A whole track of 64 words fills an even/odd pair of pages. A half track of 32 words fills one page. The controller then steps through the block one word at a time. Each word takes a read cycle at the source followed by a write cycle at the destination. Both stores are plain synchronous memories with one cycle of read latency.

A verify command reads the named track and the named page or pages side by side and records whether any word differs. A policy bit chooses what follows a mismatch. With the bit clear, the controller halts at once. With it set, the controller repeats the transfer in the direction given with the verify command and verifies again. A retry limit stops this loop and forces a halt.

The delay of the rotating medium is modelled as a wait before each pass. Passes that write the backing store wait a set number of extra cycles beyond the read wait. The halt state holds until reset.

Top module: `pstx_ctrl`

## Requirements
- R1: While reset is held and just after it, `busy`, `done`, `halt` and `mismatch` are low and no memory enable is asserted.
- R2: A whole-track load (`cmd_verify`=0, `cmd_to_backing`=0, `cmd_half`=0) copies backing word `track*64+w` to working word `(page with bit 0 cleared)*32+w` for w = 0..63. Pages P and P+1 therefore hold words 0..31 and 32..63.
- R3: With `cmd_to_backing`=1 the same mapping is used in the opposite direction: working words are written to the backing store.
- R4: With `cmd_half`=1 only 32 words move, between backing words `track*64+cmd_upper*32+i` and working words `page*32+i`. No other word of either store changes.
- R5: A verify whose copies agree finishes with `mismatch`=0 and `halt`=0 and writes neither store.
- R6: A verify that finds a difference while `cmd_retry`=0 finishes with `mismatch`=1 and `halt`=1, writes neither store, and `halt` stays high until reset.
- R7: A verify that finds a difference while `cmd_retry`=1 repeats the transfer in the direction given by `cmd_to_backing` and verifies again. If the copies then agree, it ends with `mismatch`=0 and `halt`=0.
- R8: If RETRY_LIMIT repeats all end in mismatch, the controller halts with `mismatch`=1 after exactly RETRY_LIMIT transfers.
- R9: The first write of a pass lands RD_WAIT+4 cycles after the cycle in which `start` is driven. For a pass that writes the backing store, add WR_EXTRA cycles.
- R10: `start` is ignored while `busy` is high and while `halt` is high.
- R11: `busy` is high from the cycle after `start` until the command ends. `done` is a single-cycle pulse and coincides with `busy` going low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe |
| cmd_verify | input | 1 | 1 = verify, 0 = transfer |
| cmd_to_backing | input | 1 | Direction: 1 = working to backing, 0 = backing to working |
| cmd_half | input | 1 | 1 = half track and single page |
| cmd_upper | input | 1 | Selects the upper half of the track in half mode |
| cmd_track | input | 8 | Track number |
| cmd_page | input | 3 | Page number (bit 0 is ignored in whole-track mode) |
| cmd_retry | input | 1 | Mismatch policy: 1 = retry, 0 = halt |
| busy | output | 1 | Command in progress |
| done | output | 1 | End-of-command pulse |
| mismatch | output | 1 | Result of the last verify |
| halt | output | 1 | Controller stopped, held until reset |
| bs_addr | output | 14 | Backing store word address |
| bs_rd_en | output | 1 | Backing store read |
| bs_wr_en | output | 1 | Backing store write |
| bs_wdata | output | 40 | Backing store write data |
| bs_rdata | input | 40 | Backing store read data, one cycle after read |
| ws_addr | output | 8 | Working store word address |
| ws_rd_en | output | 1 | Working store read |
| ws_wr_en | output | 1 | Working store write |
| ws_wdata | output | 40 | Working store write data |
| ws_rdata | input | 40 | Working store read data, one cycle after read |

## Verification
The assertions assume that both memories return read data exactly one cycle after a read enable. They also assume that `start` is a one-cycle strobe with its command fields stable in that cycle. The bench memory models meet the read timing. The bench drives every command as a single-cycle pulse at the falling edge.

The assertions also take it that a write to the working store may be corrupted. The bench injects such faults only through a one-bit stuck flip at one working-store address, or by changing a stored word directly between commands. Commands issued while busy or halted are deliberate, to check that they are ignored.

// File: rtl/pstx_pkg.sv
package pstx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_RD,
      ST_WR,
      ST_HALT
   } pstx_state_e;
endpackage

// File: rtl/pstx_wait_timer.sv
module pstx_wait_timer #(
   parameter int MAX_WAIT = 14,
   localparam int CW = $clog2(MAX_WAIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(MAX_WAIT)) else $error("timer out of range"); // R9
endmodule

// File: rtl/pstx_addr_gen.sv
module pstx_addr_gen #(
   parameter int TRK_W  = 8,
   parameter int PAGE_W = 3,
   parameter int IDX_W  = 6,
   localparam int BS_AW = TRK_W + IDX_W,
   localparam int WS_AW = PAGE_W + IDX_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   input  logic              half,
   input  logic              upper,
   input  logic [TRK_W-1:0]  track,
   input  logic [PAGE_W-1:0] page,
   output logic [BS_AW-1:0]  bs_addr,
   output logic [WS_AW-1:0]  ws_addr,
   output logic              last
);
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] trk_word;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) idx_q <= '0;
      else if (adv)      idx_q <= idx_q + 1'b1;
   end

   always_comb begin
      if (half) begin
         trk_word = {upper, idx_q[IDX_W-2:0]};
         ws_addr  = {page, idx_q[IDX_W-2:0]};
         last     = &idx_q[IDX_W-2:0];
      end else begin
         trk_word = idx_q;
         ws_addr  = {page[PAGE_W-1:1], idx_q};
         last     = &idx_q;
      end
   end

   assign bs_addr = {track, trk_word};

   AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      half |-> !idx_q[IDX_W-1]) else $error("half index overrun"); // R4
endmodule

// File: rtl/pstx_compare.sv
module pstx_compare #(
   parameter int WORD_W = 40,
   parameter int LANE_W = 8,
   localparam int N_LANES = WORD_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   output logic              miss_any
);
   logic [N_LANES-1:0] lane_diff;
   logic               acc_q;

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      assign lane_diff[g] = |(a[g*LANE_W +: LANE_W] ^ b[g*LANE_W +: LANE_W]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) acc_q <= 1'b0;
      else if (en)       acc_q <= acc_q | (|lane_diff);
   end

   assign miss_any = acc_q | (en & (|lane_diff));
endmodule

// File: rtl/pstx_ctrl.sv
module pstx_ctrl
   import pstx_pkg::*;
#(
   parameter int WORD_W      = 40,
   parameter int TRACK_BITS  = 2560,
   parameter int N_TRACKS    = 256,
   parameter int N_PAGES     = 8,
   parameter int RD_WAIT     = 8,
   parameter int WR_EXTRA    = 6,
   parameter int RETRY_LIMIT = 2,
   parameter int LANE_W      = 8,
   localparam int TRK_WORDS  = TRACK_BITS / WORD_W,
   localparam int TRK_W      = $clog2(N_TRACKS),
   localparam int PAGE_W     = $clog2(N_PAGES),
   localparam int IDX_W      = $clog2(TRK_WORDS),
   localparam int BS_AW      = TRK_W + IDX_W,
   localparam int WS_AW      = PAGE_W + IDX_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cmd_verify,
   input  logic              cmd_to_backing,
   input  logic              cmd_half,
   input  logic              cmd_upper,
   input  logic [TRK_W-1:0]  cmd_track,
   input  logic [PAGE_W-1:0] cmd_page,
   input  logic              cmd_retry,
   output logic              busy,
   output logic              done,
   output logic              mismatch,
   output logic              halt,
   output logic [BS_AW-1:0]  bs_addr,
   output logic              bs_rd_en,
   output logic              bs_wr_en,
   output logic [WORD_W-1:0] bs_wdata,
   input  logic [WORD_W-1:0] bs_rdata,
   output logic [WS_AW-1:0]  ws_addr,
   output logic              ws_rd_en,
   output logic              ws_wr_en,
   output logic [WORD_W-1:0] ws_wdata,
   input  logic [WORD_W-1:0] ws_rdata
);
   localparam int MAX_WAIT = RD_WAIT + WR_EXTRA;
   localparam int TW       = $clog2(MAX_WAIT + 1);
   localparam int RC_W     = $clog2(RETRY_LIMIT + 1);

   if (TRACK_BITS % WORD_W != 0) begin : g_chk_track
      $error("TRACK_BITS must be a multiple of WORD_W");
   end
   if ((1 << IDX_W) != TRK_WORDS || TRK_WORDS < 4) begin : g_chk_words
      $error("words per track must be a power of two of at least 4");
   end
   if (N_PAGES < 2 || (1 << PAGE_W) != N_PAGES) begin : g_chk_pages
      $error("N_PAGES must be a power of two of at least 2");
   end
   if (WORD_W % LANE_W != 0) begin : g_chk_lane
      $error("WORD_W must be a multiple of LANE_W");
   end
   if (RETRY_LIMIT < 1 || RD_WAIT < 0 || WR_EXTRA < 0) begin : g_chk_wait
      $error("bad wait or retry parameter");
   end

   pstx_state_e       state_q;
   logic              phase_v_q, orig_v_q, to_b_q, half_q, upper_q, retry_q;
   logic [TRK_W-1:0]  trk_q;
   logic [PAGE_W-1:0] page_q;
   logic [RC_W-1:0]   retry_cnt_q;
   logic              done_q, miss_q, halt_q;
   logic              tmr_load, tmr_expired, last, miss_any, cmp_en, accept;
   logic [TW-1:0]     tmr_val;

   localparam logic [TW-1:0] SHORT_W = TW'(RD_WAIT);
   localparam logic [TW-1:0] LONG_W  = TW'(RD_WAIT + WR_EXTRA);

   assign accept = (state_q == ST_IDLE) && start;

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = SHORT_W;
      if (accept) begin
         tmr_load = 1'b1;
         tmr_val  = (!cmd_verify && cmd_to_backing) ? LONG_W : SHORT_W;
      end else if (state_q == ST_WR && last) begin
         if (!phase_v_q && orig_v_q) begin
            tmr_load = 1'b1;
         end else if (phase_v_q && miss_any && retry_q &&
                      retry_cnt_q < RC_W'(RETRY_LIMIT)) begin
            tmr_load = 1'b1;
            tmr_val  = to_b_q ? LONG_W : SHORT_W;
         end
      end
   end

   pstx_wait_timer #(.MAX_WAIT(MAX_WAIT)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .expired(tmr_expired)
   );

   pstx_addr_gen #(.TRK_W(TRK_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .clr(tmr_load),
      .adv(state_q == ST_WR && !last),
      .half(half_q), .upper(upper_q), .track(trk_q), .page(page_q),
      .bs_addr(bs_addr), .ws_addr(ws_addr), .last(last)
   );

   assign cmp_en = (state_q == ST_WR) && phase_v_q;

   pstx_compare #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .clr(tmr_load), .en(cmp_en),
      .a(bs_rdata), .b(ws_rdata), .miss_any(miss_any)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         phase_v_q   <= 1'b0;
         orig_v_q    <= 1'b0;
         to_b_q      <= 1'b0;
         half_q      <= 1'b0;
         upper_q     <= 1'b0;
         retry_q     <= 1'b0;
         trk_q       <= '0;
         page_q      <= '0;
         retry_cnt_q <= '0;
         done_q      <= 1'b0;
         miss_q      <= 1'b0;
         halt_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start) begin
               phase_v_q   <= cmd_verify;
               orig_v_q    <= cmd_verify;
               to_b_q      <= cmd_to_backing;
               half_q      <= cmd_half;
               upper_q     <= cmd_upper;
               retry_q     <= cmd_retry;
               trk_q       <= cmd_track;
               page_q      <= cmd_page;
               retry_cnt_q <= '0;
               miss_q      <= 1'b0;
               state_q     <= ST_WAIT;
            end
            ST_WAIT: if (tmr_expired) state_q <= ST_RD;
            ST_RD:   state_q <= ST_WR;
            ST_WR: begin
               if (!last) begin
                  state_q <= ST_RD;
               end else if (!phase_v_q) begin
                  if (orig_v_q) begin
                     phase_v_q <= 1'b1;
                     state_q   <= ST_WAIT;
                  end else begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end else if (!miss_any) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (retry_q && retry_cnt_q < RC_W'(RETRY_LIMIT)) begin
                  retry_cnt_q <= retry_cnt_q + 1'b1;
                  phase_v_q   <= 1'b0;
                  state_q     <= ST_WAIT;
               end else begin
                  miss_q  <= 1'b1;
                  halt_q  <= 1'b1;
                  done_q  <= 1'b1;
                  state_q <= ST_HALT;
               end
            end
            ST_HALT: state_q <= ST_HALT;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE) && (state_q != ST_HALT);
   assign done     = done_q;
   assign mismatch = miss_q;
   assign halt     = halt_q;
   assign bs_rd_en = (state_q == ST_RD) && (phase_v_q || !to_b_q);
   assign ws_rd_en = (state_q == ST_RD) && (phase_v_q || to_b_q);
   assign bs_wr_en = (state_q == ST_WR) && !phase_v_q && to_b_q;
   assign ws_wr_en = (state_q == ST_WR) && !phase_v_q && !to_b_q;
   assign bs_wdata = ws_rdata;
   assign ws_wdata = bs_rdata;

   AST_ONE_WRITE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bs_wr_en && ws_wr_en)) else $error("both stores written"); // R3
   AST_VERIFY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en || (state_q == ST_RD && bs_rd_en && ws_rd_en)) |-> !bs_wr_en && !ws_wr_en)
      else $error("write during verify"); // R5
   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> halt) else $error("halt dropped"); // R6
   AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> !busy && !bs_wr_en && !ws_wr_en) else $error("active while halted"); // R10
   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(trk_q) && $stable(page_q) && $stable(to_b_q))
      else $error("command taken while busy"); // R10
   AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      retry_cnt_q <= RC_W'(RETRY_LIMIT)) else $error("retry over limit"); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done wider than one cycle"); // R11
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy) else $error("done while busy"); // R11
   AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT) |-> !(bs_rd_en || ws_rd_en || bs_wr_en || ws_wr_en))
      else $error("memory access during wait"); // R9
endmodule

// File: tb/pstx_ctrl_tb.sv
module pstx_ctrl_tb;
   localparam int RD_WAIT     = 8;
   localparam int WR_EXTRA    = 6;
   localparam int RETRY_LIMIT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        cmd_verify = 1'b0, cmd_to_backing = 1'b0, cmd_half = 1'b0;
   logic        cmd_upper = 1'b0, cmd_retry = 1'b0;
   logic [7:0]  cmd_track = '0;
   logic [2:0]  cmd_page = '0;
   logic        busy, done, mismatch, halt;
   logic [13:0] bs_addr;
   logic        bs_rd_en, bs_wr_en, ws_rd_en, ws_wr_en;
   logic [39:0] bs_wdata, ws_wdata;
   logic [39:0] bs_rdata = '0, ws_rdata = '0;
   logic [7:0]  ws_addr;

   always #2 clk = ~clk;

   pstx_ctrl #(.RD_WAIT(RD_WAIT), .WR_EXTRA(WR_EXTRA), .RETRY_LIMIT(RETRY_LIMIT)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_verify(cmd_verify),
      .cmd_to_backing(cmd_to_backing), .cmd_half(cmd_half), .cmd_upper(cmd_upper),
      .cmd_track(cmd_track), .cmd_page(cmd_page), .cmd_retry(cmd_retry),
      .busy(busy), .done(done), .mismatch(mismatch), .halt(halt),
      .bs_addr(bs_addr), .bs_rd_en(bs_rd_en), .bs_wr_en(bs_wr_en),
      .bs_wdata(bs_wdata), .bs_rdata(bs_rdata),
      .ws_addr(ws_addr), .ws_rd_en(ws_rd_en), .ws_wr_en(ws_wr_en),
      .ws_wdata(ws_wdata), .ws_rdata(ws_rdata)
   );

   // memory models
   logic [39:0] bs_mem [int];
   logic [39:0] ws_mem [256];
   logic        fault_en = 1'b0;
   logic [7:0]  fault_addr = '0;

   function automatic logic [39:0] bpat(int t, int w);
      logic [31:0] t32 = 32'(t);
      logic [31:0] w32 = 32'(w);
      logic [31:0] m = t32 * 977 + w32 * 31 + 4660;
      return {t32[7:0] ^ 8'h5A, w32[7:0], m[23:0]};
   endfunction

   function automatic logic [39:0] wpat(int a);
      logic [31:0] a32 = 32'(a);
      return {8'hC3, a32[7:0], 24'h00F0F0 ^ {a32[7:0], a32[7:0], a32[7:0]}};
   endfunction

   function automatic logic [39:0] bs_read(int a);
      if (bs_mem.exists(a)) return bs_mem[a];
      return bpat(a >> 6, a & 63);
   endfunction

   always @(posedge clk) begin
      if (bs_rd_en) bs_rdata <= bs_read(int'(bs_addr));
      if (ws_rd_en) ws_rdata <= ws_mem[ws_addr];
      if (bs_wr_en) bs_mem[int'(bs_addr)] = bs_wdata;
      if (ws_wr_en) ws_mem[ws_addr] <= (fault_en && ws_addr == fault_addr) ?
                                         (ws_wdata ^ 40'd1) : ws_wdata;
   end

   // monitor
   int cyc = 0;
   int ws_wr_cnt = 0, bs_wr_cnt = 0;
   int first_ws = -1, first_bs = -1;
   always @(posedge clk) begin
      cyc = cyc + 1;
      if (ws_wr_en) begin
         ws_wr_cnt = ws_wr_cnt + 1;
         if (first_ws < 0) first_ws = cyc;
      end
      if (bs_wr_en) begin
         bs_wr_cnt = bs_wr_cnt + 1;
         if (first_bs < 0) first_bs = cyc;
      end
   end

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(bit ok, string req, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      ws_wr_cnt = 0; bs_wr_cnt = 0; first_ws = -1; first_bs = -1;
   endtask

   int start_cyc;

   task automatic issue(bit v, bit tob, bit hf, bit up, int trk, int pg, bit rt);
      @(negedge clk);
      cmd_verify = v; cmd_to_backing = tob; cmd_half = hf; cmd_upper = up;
      cmd_track = 8'(trk); cmd_page = 3'(pg); cmd_retry = rt;
      start = 1'b1;
      start_cyc = cyc;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(string req);
      int n = 0;
      chk(busy === 1'b1, req, busy, 1);
      while (done !== 1'b1 && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk(done === 1'b1 && busy === 1'b0, req, {busy, done}, 1);
      @(negedge clk);
      chk(done === 1'b0, {req, " done pulse"}, done, 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk({busy, done, halt, mismatch, bs_wr_en, ws_wr_en, bs_rd_en, ws_rd_en} === 8'h0,
          "R1 during reset", {busy, done, halt, mismatch}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, halt, mismatch, bs_wr_en, ws_wr_en} === 6'h0,
          "R1 after reset", {busy, done, halt, mismatch}, 0);
   endtask

   int load_lat, store_lat;

   task automatic t_load_full();
      int err = 0;
      clear_mon();
      issue(0, 0, 0, 0, 5, 3, 0);
      wait_done("R11 load full");
      for (int w = 0; w < 64; w++) if (ws_mem[64 + w] !== bpat(5, w)) err++;
      chk(err == 0, "R2 track 5 into pages 2/3", err, 0);
      chk(ws_wr_cnt == 64 && bs_wr_cnt == 0, "R2 write count", ws_wr_cnt, 64);
      load_lat = first_ws - start_cyc;
      chk(load_lat == RD_WAIT + 4, "R9 read-side latency", load_lat, RD_WAIT + 4);
   endtask

   task automatic t_load_half();
      int err = 0;
      for (int i = 0; i < 32; i++) ws_mem[224 + i] = 40'hDEAD00 + 40'(i);
      clear_mon();
      issue(0, 0, 1, 1, 7, 6, 0);
      wait_done("R11 load half");
      for (int i = 0; i < 32; i++) if (ws_mem[192 + i] !== bpat(7, 32 + i)) err++;
      chk(err == 0, "R4 upper half into page 6", err, 0);
      err = 0;
      for (int i = 0; i < 32; i++) if (ws_mem[224 + i] !== 40'hDEAD00 + 40'(i)) err++;
      chk(err == 0, "R4 page 7 untouched", err, 0);
      clear_mon();
      issue(0, 0, 1, 0, 8, 1, 0);
      wait_done("R11 load half low");
      err = 0;
      for (int i = 0; i < 32; i++) if (ws_mem[32 + i] !== bpat(8, i)) err++;
      chk(err == 0 && ws_wr_cnt == 32, "R4 lower half into page 1", err, 0);
   endtask

   task automatic t_store_full();
      int err = 0;
      for (int a = 64; a < 128; a++) ws_mem[a] = wpat(a);
      clear_mon();
      issue(0, 1, 0, 0, 9, 2, 0);
      wait_done("R11 store full");
      for (int w = 0; w < 64; w++) if (bs_read(9 * 64 + w) !== wpat(64 + w)) err++;
      chk(err == 0, "R3 pages 2/3 into track 9", err, 0);
      chk(bs_wr_cnt == 64 && ws_wr_cnt == 0, "R3 write count", bs_wr_cnt, 64);
      store_lat = first_bs - start_cyc;
      chk(store_lat - load_lat == WR_EXTRA, "R9 extra write wait",
          store_lat - load_lat, WR_EXTRA);
   endtask

   task automatic t_store_half();
      int err = 0;
      for (int a = 160; a < 192; a++) ws_mem[a] = wpat(a);
      clear_mon();
      issue(0, 1, 1, 1, 10, 5, 0);
      wait_done("R11 store half");
      for (int i = 0; i < 32; i++) if (bs_read(640 + 32 + i) !== wpat(160 + i)) err++;
      chk(err == 0, "R4 page 5 into upper half of track 10", err, 0);
      err = 0;
      for (int i = 0; i < 32; i++) if (bs_read(640 + i) !== bpat(10, i)) err++;
      chk(err == 0 && bs_wr_cnt == 32, "R4 lower half of track 10 untouched", err, 0);
   endtask

   task automatic t_verify_match();
      clear_mon();
      issue(1, 0, 0, 0, 9, 3, 0);
      wait_done("R11 verify");
      chk(mismatch === 1'b0 && halt === 1'b0, "R5 verify match", {mismatch, halt}, 0);
      chk(ws_wr_cnt == 0 && bs_wr_cnt == 0, "R5 verify writes nothing",
          ws_wr_cnt + bs_wr_cnt, 0);
   endtask

   task automatic t_ignore_busy();
      int err = 0;
      for (int a = 128; a < 160; a++) ws_mem[a] = 40'hBEEF00 + 40'(a);
      clear_mon();
      issue(0, 0, 0, 0, 11, 0, 0);
      repeat (20) @(negedge clk);
      issue(0, 0, 1, 0, 12, 4, 0);
      wait_done("R11 busy run");
      repeat (3) @(negedge clk);
      chk(busy === 1'b0, "R10 no second command", busy, 0);
      for (int a = 128; a < 160; a++) if (ws_mem[a] !== 40'hBEEF00 + 40'(a)) err++;
      chk(err == 0 && ws_wr_cnt == 64, "R10 start ignored while busy", ws_wr_cnt, 64);
      err = 0;
      for (int w = 0; w < 64; w++) if (ws_mem[w] !== bpat(11, w)) err++;
      chk(err == 0, "R10 first command intact", err, 0);
   endtask

   task automatic t_retry_ok();
      ws_mem[74] = ws_mem[74] ^ 40'h100;
      clear_mon();
      issue(1, 0, 0, 0, 9, 2, 1);
      wait_done("R11 retry");
      chk(mismatch === 1'b0 && halt === 1'b0, "R7 retry recovers", {mismatch, halt}, 0);
      chk(ws_mem[74] === wpat(74), "R7 word restored", ws_mem[74], wpat(74));
      chk(ws_wr_cnt == 64 && bs_wr_cnt == 0, "R7 one reload", ws_wr_cnt, 64);
   endtask

   task automatic t_halt_policy();
      ws_mem[70] = ws_mem[70] ^ 40'h8;
      clear_mon();
      issue(1, 0, 0, 0, 9, 2, 0);
      wait_done("R11 halt policy");
      chk(mismatch === 1'b1 && halt === 1'b1, "R6 halt on mismatch", {mismatch, halt}, 3);
      chk(ws_wr_cnt == 0 && bs_wr_cnt == 0, "R6 no writes", ws_wr_cnt + bs_wr_cnt, 0);
      issue(0, 0, 0, 0, 5, 0, 0);
      repeat (30) @(negedge clk);
      chk(busy === 1'b0 && halt === 1'b1 && ws_wr_cnt == 0,
          "R10 start ignored while halted", {busy, halt}, 1);
      do_reset();
      chk(halt === 1'b0 && mismatch === 1'b0, "R1 reset clears halt", {halt, mismatch}, 0);
   endtask

   task automatic t_retry_limit();
      fault_en = 1'b1;
      fault_addr = 8'd200;
      ws_mem[200] = ws_mem[200] ^ 40'd1;
      clear_mon();
      issue(1, 0, 1, 1, 7, 6, 1);
      wait_done("R11 retry limit");
      chk(halt === 1'b1 && mismatch === 1'b1, "R8 halt after limit", {halt, mismatch}, 3);
      chk(ws_wr_cnt == RETRY_LIMIT * 32, "R8 transfer count", ws_wr_cnt, RETRY_LIMIT * 32);
      fault_en = 1'b0;
   endtask

   initial begin
      t_reset();
      t_load_full();
      t_load_half();
      t_store_full();
      t_store_half();
      t_verify_match();
      t_ignore_busy();
      t_retry_ok();
      t_halt_policy();
      t_retry_limit();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule